// File: doc/BRIEF.md
# Hierarchical Vertical-and-Crosswise Significand Multiplier

This block multiplies two unsigned 24-bit operands and returns their full 48-bit product with no clock and no state. It serves as the significand (mantissa plus hidden one) stage of a single-precision floating-point multiply. Its delay is fixed and does not depend on the data.

The structure is recursive. A 3x3 cell forms its result from column sums, the vertical and crosswise terms. Each wider level splits both operands into a high half and a low half. It forms the four half-width sub-products in parallel, then adds them with shifts of zero, one half-width and two half-widths. The levels run 3 to 6, 6 to 12 and 12 to 24 bits. Each level is its own module, so a neighbouring datapath can reuse the 6x6 or 12x12 units.

Top module: `vedic_mul24`

## Requirements
- R1: For every pair of 24-bit unsigned operands, `prod` equals the exact 48-bit unsigned product of `opA` and `opB`.
- R2: When either operand is zero, all 48 bits of `prod` are zero.
- R3: When one operand equals 1, `prod` equals the other operand, zero-extended to 48 bits.
- R4: When both operands are all ones (0xFFFFFF), `prod` equals 0xFFFFFE000001.
- R5: When both operands are below 8, so that only the lowest 3x3 cell sees nonzero bits, `prod[5:0]` holds their product and `prod[47:6]` is zero.
- R6: Swapping the operands leaves `prod` unchanged.
- R7: When one operand is 2^k (k from 0 to 23), `prod` equals the other operand shifted left by k bits. This holds in particular at k = 3, 6 and 12, where the single one moves across a sub-block boundary.
- R8: `prod` depends only on the present operands. The same operand pair gives the same result whatever pairs were applied before it.
- R9: Carries produced when the shifted sub-products are added travel through every level. Operands whose 3-, 6- and 12-bit halves are all ones still give the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 24 | Unsigned multiplicand |
| opB | input | 24 | Unsigned multiplier |
| prod | output | 48 | Unsigned full-width product |

## Verification
The hardest case to reach is a carry that starts in the adder of one level and ripples through the adders of every level above it. This needs dense runs of ones inside particular half-blocks, and uniform random operands seldom produce them. The stimulus therefore mixes uniform random pairs with pairs whose random masks are ORed together to give dense operands. It adds directed patterns in which whole 3-, 6- and 12-bit halves are all ones, and single powers of two placed on each sub-block boundary.

// File: rtl/vedic_pkg.sv
package vedic_pkg;
  localparam int BaseW = 3;
  localparam int TopW  = 24;
  localparam int ProdW = 2 * TopW;
endpackage

// File: rtl/vedic_cell3.sv
module vedic_cell3 (
  input  logic [2:0] a,
  input  logic [2:0] b,
  output logic [5:0] p
);
  logic [1:0] colSum1;
  logic [2:0] colSum2;
  logic [2:0] colSum3;
  logic [1:0] colSum4;

  always_comb begin
    // column 1: two crosswise terms
    colSum1 = {1'b0, a[1] & b[0]} + {1'b0, a[0] & b[1]};
    // column 2: three terms plus carry from column 1
    colSum2 = {2'b0, a[2] & b[0]} + {2'b0, a[1] & b[1]} + {2'b0, a[0] & b[2]}
            + {2'b0, colSum1[1]};
    // column 3: two terms plus carry (up to 2) from column 2
    colSum3 = {2'b0, a[2] & b[1]} + {2'b0, a[1] & b[2]} + {1'b0, colSum2[2:1]};
    // column 4: single vertical term plus carry
    colSum4 = {1'b0, a[2] & b[2]} + colSum3[2:1];
    p = {colSum4, colSum3[0], colSum2[0], colSum1[0], a[0] & b[0]};
  end
endmodule

// File: rtl/vedic_combine.sv
module vedic_combine #(
  parameter int HALF = 3
) (
  input  logic [2*HALF-1:0] prodLL,
  input  logic [2*HALF-1:0] prodHL,
  input  logic [2*HALF-1:0] prodLH,
  input  logic [2*HALF-1:0] prodHH,
  output logic [4*HALF-1:0] sum
);
  localparam int OutW = 4 * HALF;
  logic [OutW-1:0] outerTerm;
  logic [OutW-1:0] crossA;
  logic [OutW-1:0] crossB;

  always_comb begin
    outerTerm = {prodHH, prodLL};
    crossA    = {{HALF{1'b0}}, prodHL, {HALF{1'b0}}};
    crossB    = {{HALF{1'b0}}, prodLH, {HALF{1'b0}}};
    sum       = outerTerm + crossA + crossB;
  end
endmodule

// File: rtl/vedic_mul6.sv
module vedic_mul6 (
  input  logic [5:0]  a,
  input  logic [5:0]  b,
  output logic [11:0] p
);
  localparam int Half = 3;
  logic [2*Half-1:0] partProd [4];

  // quadrant q: bit0 picks high half of a, bit1 picks high half of b
  for (genvar q = 0; q < 4; q++) begin : g_quad
    vedic_cell3 u_cell (
      .a(a[(q % 2) * Half +: Half]),
      .b(b[(q / 2) * Half +: Half]),
      .p(partProd[q])
    );
  end

  vedic_combine #(.HALF(Half)) u_sum (
    .prodLL(partProd[0]), .prodHL(partProd[1]),
    .prodLH(partProd[2]), .prodHH(partProd[3]),
    .sum(p)
  );
endmodule

// File: rtl/vedic_mul12.sv
module vedic_mul12 (
  input  logic [11:0] a,
  input  logic [11:0] b,
  output logic [23:0] p
);
  localparam int Half = 6;
  logic [2*Half-1:0] partProd [4];

  for (genvar q = 0; q < 4; q++) begin : g_quad
    vedic_mul6 u_sub (
      .a(a[(q % 2) * Half +: Half]),
      .b(b[(q / 2) * Half +: Half]),
      .p(partProd[q])
    );
  end

  vedic_combine #(.HALF(Half)) u_sum (
    .prodLL(partProd[0]), .prodHL(partProd[1]),
    .prodLH(partProd[2]), .prodHH(partProd[3]),
    .sum(p)
  );
endmodule

// File: rtl/vedic_mul24.sv
module vedic_mul24
  import vedic_pkg::*;
(
  input  logic [TopW-1:0]  opA,
  input  logic [TopW-1:0]  opB,
  output logic [ProdW-1:0] prod
);
  localparam int Half = TopW / 2;
  logic [2*Half-1:0] partProd [4];

  for (genvar q = 0; q < 4; q++) begin : g_quad
    vedic_mul12 u_sub (
      .a(opA[(q % 2) * Half +: Half]),
      .b(opB[(q / 2) * Half +: Half]),
      .p(partProd[q])
    );
  end

  vedic_combine #(.HALF(Half)) u_sum (
    .prodLL(partProd[0]), .prodHL(partProd[1]),
    .prodLH(partProd[2]), .prodHH(partProd[3]),
    .sum(prod)
  );
endmodule

// File: rtl/vedic_mul24_chk.sv
module vedic_mul24_chk (
  input logic [23:0] opA,
  input logic [23:0] opB,
  input logic [47:0] prod
);
  logic [47:0] refProd;

  always_comb begin
    refProd = {24'b0, opA} * {24'b0, opB};
    a_r1_exact_product: assert (prod == refProd);
    a_r2_zero_operand: assert (!((opA == 24'd0) || (opB == 24'd0)) || (prod == 48'd0));
    a_r3_unit_operand: assert (!(opA == 24'd1) || (prod == {24'b0, opB}));
    a_r4_all_ones: assert (!((opA == 24'hFFFFFF) && (opB == 24'hFFFFFF))
                           || (prod == 48'hFFFFFE000001));
    a_r5_base_cell_range: assert (!((opA < 24'd8) && (opB < 24'd8))
                                  || (prod[47:6] == 42'd0));
  end
endmodule

bind vedic_mul24 vedic_mul24_chk u_chk (
  .opA(opA), .opB(opB), .prod(prod)
);

// File: tb/vedic_mul24_tb.sv
module vedic_mul24_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [23:0] opA = 24'd0;
  logic [23:0] opB = 24'd0;
  logic [47:0] prod;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vedic_mul24 u_dut (.opA(opA), .opB(opB), .prod(prod));

  // shift-and-add reference, written from the requirement
  function automatic logic [47:0] refMul(logic [23:0] x, logic [23:0] y);
    logic [47:0] acc = 48'd0;
    for (int i = 0; i < 24; i++)
      if (y[i]) acc = acc + ({24'b0, x} << i);
    return acc;
  endfunction

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, opA, opB, act, exp);
    end
  endtask

  task automatic apply(logic [23:0] x, logic [23:0] y);
    @(negedge clk);
    opA = x;
    opB = y;
    #1;
  endtask

  task automatic runPair(string req, logic [23:0] x, logic [23:0] y);
    apply(x, y);
    check(req, prod, refMul(x, y));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] first;
    logic [23:0] x;
    logic [23:0] y;
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R2 reset-state zero operands", prod, 48'd0);

    // R2 zero operand
    runPair("R2", 24'd0, 24'hABCDEF);
    check("R2 zero", prod, 48'd0);
    runPair("R2", 24'hFFFFFF, 24'd0);
    // R3 unit operand
    apply(24'd1, 24'h5A5A5A);
    check("R3", prod, 48'h5A5A5A);
    apply(24'hC3C3C3, 24'd1);
    check("R3", prod, 48'hC3C3C3);
    // R4 all ones
    apply(24'hFFFFFF, 24'hFFFFFF);
    check("R4", prod, 48'hFFFFFE000001);
    // R5 base-cell range, exhaustive
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        apply(24'(i), 24'(j));
        check("R5", prod, 48'(i * j));
      end
    // R7 powers of two on every position
    for (int k = 0; k < 24; k++) begin
      apply(24'd1 << k, 24'hB7E151);
      check("R7", prod, {24'b0, 24'hB7E151} << k);
    end
    // R9 dense half blocks at every level
    runPair("R9", 24'h000007, 24'h000007);
    runPair("R9", 24'h00003F, 24'h00003F);
    runPair("R9", 24'h000FFF, 24'h000FFF);
    runPair("R9", 24'hFFF000, 24'h000FFF);
    runPair("R9", 24'hFC0FC0, 24'hFFFFFF);
    runPair("R9", 24'hE38E38, 24'h1C71C7);
    runPair("R9", 24'h7FFFFF, 24'hFFFFFE);
    // R8 history independence
    apply(24'h123456, 24'h654321);
    first = prod;
    apply(24'hFFFFFF, 24'hFFFFFF);
    apply(24'h123456, 24'h654321);
    check("R8", prod, first);
    check("R8 value", prod, refMul(24'h123456, 24'h654321));
    // R1 / R6 random, uniform and dense
    for (int n = 0; n < 3000; n++) begin
      x = 24'($urandom());
      y = 24'($urandom());
      if (n % 3 == 1) begin
        x = x | 24'($urandom()) | 24'($urandom());
        y = y | 24'($urandom()) | 24'($urandom());
      end
      runPair("R1", x, y);
      first = prod;
      apply(y, x);
      check("R6", prod, first);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule